// File: doc/BRIEF.md
# Horizontal Scanline Sync and Blanking Generator

This block produces the horizontal timing of a raster display without a counter or comparators. A scanline is divided into 32 equal time units. A divider outside the block supplies a one-clock tick once per unit, for example every 99 cycles of a 100 MHz clock, which gives a 31.68 us line. The block holds a 32-stage circular register loaded with a fixed bit pattern. The register rotates one stage on each tick, and the bit at its output stage forms the sync pulse.

Blanking comes from the same register. It is the OR of two taps: one stage ahead of the output and two stages behind it. The blanking window therefore covers the front porch, the sync pulse and the back porch, and the visible part of the line starts right after it ends. A one-clock line-start strobe tells the vertical timing logic that a new sync pulse is about to begin.

Top module: `hline_gen`

## Requirements
- R1: Synchronous active-high reset loads the pattern and places the line at unit 0. Once reset has been sampled, `hsync_n` is 1, `hblank` is 0 and `line_start` is 0.
- R2: The line position advances by exactly one unit on each clock edge where `unit_tick` is 1, and holds while `unit_tick` is 0.
- R3: The line is 32 units long. After unit 31 the position returns to unit 0, so a tick every clock gives one `line_start` pulse per 32 ticks.
- R4: `hsync_n` is low (active-low sync) exactly during units 2, 3, 4 and 5, and high in every other unit.
- R5: `hblank` is high (active-high) during units 1 through 7. This window is the 1-unit front porch (unit 1), the 4-unit sync and the 2-unit back porch (units 6 and 7).
- R6: `hblank` is low during the 25 visible units, units 8 through 31 and unit 0.
- R7: `line_start` is 1 for a single clock exactly when `unit_tick` is 1 while the line is at unit 1, so that the sync pulse begins on the next edge.
- R8: A reset in the middle of a line restarts the line at unit 0. Ticks that arrive while reset is high are ignored, and `line_start` stays 0 while reset is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_tick | input | 1 | One-clock strobe marking the end of each time unit |
| hsync_n | output | 1 | Horizontal sync, active low |
| hblank | output | 1 | Horizontal blanking, active high |
| line_start | output | 1 | One-clock strobe just before sync begins |

## Verification
The tick is driven in four patterns:
- **Every clock.** This packs whole lines into a few hundred cycles and exposes the wrap from unit 31 to unit 0 and the line period.
- **Every third clock.** This shows that the outputs hold between ticks.
- **Pseudo-random.** This catches a design that counts clocks instead of ticks.
- **Every 99 clocks.** This is the nominal rate, with long idle stretches.

Resets are also applied in the middle of a line while ticks keep arriving. Every output is compared on every clock against a unit index the bench keeps itself. This separates the sync window from the blanking window, distinguishes the front-porch tap from the back-porch tap, and exposes an off-by-one in the strobe.

// File: rtl/hline_pkg.sv
package hline_pkg;

    // Default scanline geometry, in time units
    localparam int unsigned LINE_UNITS_D  = 32;
    localparam int unsigned SYNC_UNITS_D  = 4;
    localparam int unsigned FRONT_UNITS_D = 1;
    localparam int unsigned BACK_UNITS_D  = 2;
    localparam int unsigned SYNC_START_D  = 2;

    // Bundle of the timing outputs
    typedef struct packed {
        logic hsync_n;
        logic hblank;
        logic line_start;
    } hline_out_t;

    // Whether unit u falls inside the sync window
    function automatic logic in_sync(input int unsigned u,
                                     input int unsigned start,
                                     input int unsigned width);
        return (u >= start) && (u < start + width);
    endfunction

endpackage

// File: rtl/hline_ring.sv
module hline_ring #(
    parameter int unsigned LEN        = 32,
    parameter int unsigned SYNC_START = 2,
    parameter int unsigned SYNC_UNITS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rot_en,
    output logic [LEN-1:0] stages
);
    import hline_pkg::*;

    // Stage LEN-1 is the output; it holds unit 0 after reset
    logic [LEN-1:0] preload;

    generate
        for (genvar i = 0; i < LEN; i++) begin : g_pre
            assign preload[i] = in_sync(LEN - 1 - i, SYNC_START, SYNC_UNITS);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= preload;
        end else if (rot_en) begin
            stages <= {stages[LEN-2:0], stages[LEN-1]};
        end
    end

endmodule

// File: rtl/hline_taps.sv
module hline_taps #(
    parameter int unsigned LEN         = 32,
    parameter int unsigned FRONT_UNITS = 1,
    parameter int unsigned BACK_UNITS  = 2
) (
    input  logic                  rst,
    input  logic                  unit_tick,
    input  logic [LEN-1:0]        stages,
    output hline_pkg::hline_out_t tim
);
    localparam int unsigned OUT_IDX   = LEN - 1;
    localparam int unsigned AHEAD_IDX = LEN - 1 - FRONT_UNITS;
    localparam int unsigned BEHIND_IDX = BACK_UNITS - 1;
    localparam int unsigned NEXT_IDX  = LEN - 2;

    always_comb begin
        tim.hsync_n    = ~stages[OUT_IDX];
        tim.hblank     = stages[AHEAD_IDX] | stages[BEHIND_IDX];
        tim.line_start = unit_tick & ~rst & stages[NEXT_IDX] & ~stages[OUT_IDX];
    end

endmodule

// File: rtl/hline_gen.sv
module hline_gen #(
    parameter int unsigned LINE_UNITS  = hline_pkg::LINE_UNITS_D,
    parameter int unsigned SYNC_UNITS  = hline_pkg::SYNC_UNITS_D,
    parameter int unsigned FRONT_UNITS = hline_pkg::FRONT_UNITS_D,
    parameter int unsigned BACK_UNITS  = hline_pkg::BACK_UNITS_D,
    parameter int unsigned SYNC_START  = hline_pkg::SYNC_START_D
) (
    input  logic clk,
    input  logic rst,
    input  logic unit_tick,
    output logic hsync_n,
    output logic hblank,
    output logic line_start
);
    import hline_pkg::*;

    logic [LINE_UNITS-1:0] stages;
    hline_out_t            tim;

    hline_ring #(
        .LEN        (LINE_UNITS),
        .SYNC_START (SYNC_START),
        .SYNC_UNITS (SYNC_UNITS)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .rot_en (unit_tick),
        .stages (stages)
    );

    hline_taps #(
        .LEN         (LINE_UNITS),
        .FRONT_UNITS (FRONT_UNITS),
        .BACK_UNITS  (BACK_UNITS)
    ) u_taps (
        .rst       (rst),
        .unit_tick (unit_tick),
        .stages    (stages),
        .tim       (tim)
    );

    assign hsync_n    = tim.hsync_n;
    assign hblank     = tim.hblank;
    assign line_start = tim.line_start;

endmodule

// File: rtl/hline_gen_chk.sv
module hline_gen_chk (
    input logic clk,
    input logic rst,
    input logic unit_tick,
    input logic hsync_n,
    input logic hblank,
    input logic line_start
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (hsync_n && !hblank && !line_start));

    // R2
    hold_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !unit_tick |=> $stable(hsync_n) && $stable(hblank));

    // R5
    sync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> hblank);

    // R7
    strobe_leads_sync_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (hsync_n && hblank));

    // R7
    strobe_then_sync_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> $fell(hsync_n));

    // R8
    no_strobe_in_reset_chk: assert property (@(posedge clk)
        rst |-> !line_start);

endmodule

bind hline_gen hline_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .unit_tick  (unit_tick),
    .hsync_n    (hsync_n),
    .hblank     (hblank),
    .line_start (line_start)
);

// File: tb/hline_gen_tb.sv
`timescale 1ns/1ps
module hline_gen_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic unit_tick = 1'b0;
    logic hsync_n, hblank, line_start;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    int unsigned unit_idx = 0;   // bench-side line position
    int unsigned strobe_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic started = 1'b0;

    always #2.5 clk = ~clk;

    hline_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .unit_tick  (unit_tick),
        .hsync_n    (hsync_n),
        .hblank     (hblank),
        .line_start (line_start)
    );

    // Bench line position: R2, R3, R8
    always @(posedge clk) begin
        cyc <= cyc + 1;
        started <= 1'b1;
        if (rst) unit_idx <= 0;
        else if (unit_tick) unit_idx <= (unit_idx + 1) % 32;
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d unit %0d: actual %b expected %b",
                     tag, cyc, unit_idx, act, exp);
        end
    endtask

    // Compare all outputs against the unit-indexed expectation
    task automatic check_all();
        logic e_sync, e_blank, e_strobe;
        e_sync   = (unit_idx >= 2) && (unit_idx <= 5);                 // R4
        e_blank  = (unit_idx >= 1) && (unit_idx <= 7);                 // R5, R6
        e_strobe = unit_tick && !rst && (unit_idx == 1);               // R7, R8
        check("R4 hsync_n", hsync_n, !e_sync);
        check(e_blank ? "R5 hblank" : "R6 hblank", hblank, e_blank);
        check(rst ? "R8 line_start" : "R7 line_start", line_start, e_strobe);
        if (line_start) strobe_cnt++;
    endtask

    // mode 0: every clock, 1: every third, 2: pseudo-random, 3: every 99
    task automatic run(input int mode, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            check_all();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: unit_tick = 1'b1;
                1: unit_tick = (k % 3 == 2);
                2: unit_tick = lfsr[0];
                default: unit_tick = (k % 99 == 98);
            endcase
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 hsync_n", hsync_n, 1'b1);
        check("R1 hblank", hblank, 1'b0);
        check("R1 line_start", line_start, 1'b0);

        // R3: 320 ticks from unit 0 give strobes at ticks k with k%32==1
        strobe_cnt = 0;
        unit_tick = 1'b1;
        run(0, 320);
        check("R3 strobe count", (strobe_cnt == (320 + 30) / 32), 1'b1);

        // R2: hold between ticks
        unit_tick = 1'b0;
        run(1, 300);
        run(2, 2000);

        // R8: reset mid-line with ticks still arriving
        @(negedge clk);
        rst = 1'b1;
        unit_tick = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check_all();
        end
        rst = 1'b0;
        check("R8 hsync_n after reset", hsync_n, 1'b1);
        check("R8 hblank after reset", hblank, 1'b0);
        run(0, 40);

        // Nominal rate: 99 clocks per unit, two lines
        run(3, 99 * 64);
        run(2, 1000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule